// File: doc/BRIEF.md
# Branch Target Address Generator

This block works out where a taken branch goes in a 16-bit segmented controller. It takes the current code segment and the address of the instruction after the branch. It produces the new segment and the new instruction pointer in the same cycle, with no registers on the way. A 24-bit fetch address is then `{new_seg, new_ip}`.

A two-bit mode selects one of four target forms:
- an absolute address in the current segment, optionally with a new segment operand;
- a signed word offset from the following instruction;
- a raw word register value;
- a software trap number that points into the vector table in segment 0.

The block does not align an odd target. It raises a trap request and keeps the pointer on the following instruction.

There are no states. The choice of target form is a pure decode of the mode, and the odd-address check overrides that choice.

Top module: `brt_target_gen`

## Requirements
- R1: Mode encoding is 00 absolute, 01 relative, 10 indirect, 11 trap. In absolute mode with `seg_load`=0, `new_ip` equals `abs_addr`, `new_seg` equals `cur_seg` and `seg_upd` is 0.
- R2: In absolute mode with `seg_load`=1, `new_seg` equals `seg_op[7:0]`, bits 15:8 of `seg_op` have no effect, and `seg_upd` is 1.
- R3: In absolute or indirect mode, a target with bit 0 set drives `odd_trap` to 1. `new_ip` then equals `next_ip`, `new_seg` equals `cur_seg` and `seg_upd` is 0.
- R4: In relative mode, `new_ip` equals `next_ip` plus twice the sign-extended `rel_off`, modulo 2^16. Offsets 00h..7Fh move forward and 80h..FFh move backward. The segment is kept and `seg_upd` is 0.
- R5: In relative mode, offset FFh with `long_insn`=0 and offset FEh with `long_insn`=1 both land on the branch's own address. That address is `next_ip` minus 2 or minus 4.
- R6: `spin` is 1 exactly when the mode is relative and `new_ip` equals the branch's own address. Otherwise it is 0.
- R7: In indirect mode, `new_ip` is the raw `ind_val` with no translation. The segment is kept, and `seg_load` and `seg_op` have no effect.
- R8: In trap mode, `new_seg` is 0, `new_ip` is `trap_no` times 4 (range 0000h..01FCh), and `seg_upd` is 1.
- R9: `odd_trap` is never 1 in relative or trap mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mode | input | 2 | Target form: 00 abs, 01 rel, 10 ind, 11 trap |
| cur_seg | input | 8 | Current code segment |
| next_ip | input | 16 | Address of the instruction after the branch |
| abs_addr | input | 16 | Absolute target operand |
| rel_off | input | 8 | Signed word offset |
| ind_val | input | 16 | Word register value for indirect form |
| trap_no | input | 7 | Software trap number |
| seg_op | input | 16 | Segment operand; only bits 7:0 are used |
| seg_load | input | 1 | Absolute form carries a new segment |
| long_insn | input | 1 | Branch is two words long |
| new_seg | output | 8 | Next code segment |
| new_ip | output | 16 | Next instruction pointer |
| seg_upd | output | 1 | Segment register is written |
| odd_trap | output | 1 | Odd target; hardware trap request |
| spin | output | 1 | Relative branch targets itself |

## Verification
The bench builds the block with its default widths: 16-bit pointer, 8-bit segment, 8-bit offset and 7-bit trap number. At these widths the full trap table and the whole offset range can be covered, as well as wraparound at both ends of the 64 KiB segment. Random vectors across all four modes are mixed with directed cases at offsets 7Fh, 80h, FEh and FFh. They also cover odd absolute and indirect targets and trap numbers 0 and 7Fh.

// File: rtl/brt_pkg.sv
package brt_pkg;
    typedef enum logic [1:0] {
        BR_ABS  = 2'b00,
        BR_REL  = 2'b01,
        BR_IND  = 2'b10,
        BR_TRAP = 2'b11
    } br_mode_e;
endpackage

// File: rtl/brt_rel_add.sv
module brt_rel_add #(
    parameter int IP_W  = 16,
    parameter int OFF_W = 8
) (
    input  logic [IP_W-1:0]  next_ip,
    input  logic [OFF_W-1:0] rel_off,
    input  logic             long_insn,
    output logic [IP_W-1:0]  rel_ip,
    output logic             self_hit
);
    localparam int EXT_W = IP_W - OFF_W - 1;

    logic [IP_W-1:0] disp;
    logic [IP_W-1:0] own_addr;

    always_comb begin
        disp     = {{EXT_W{rel_off[OFF_W-1]}}, rel_off, 1'b0};
        rel_ip   = next_ip + disp;
        own_addr = next_ip - (long_insn ? IP_W'(4) : IP_W'(2));
        self_hit = (rel_ip == own_addr);
    end
endmodule

// File: rtl/brt_trap_vec.sv
module brt_trap_vec #(
    parameter int IP_W   = 16,
    parameter int TRAP_W = 7
) (
    input  logic [TRAP_W-1:0] trap_no,
    output logic [IP_W-1:0]   vec_ip
);
    localparam int SLOT_SH = 2;
    localparam int PAD_W   = IP_W - TRAP_W - SLOT_SH;

    assign vec_ip = {{PAD_W{1'b0}}, trap_no, {SLOT_SH{1'b0}}};
endmodule

// File: rtl/brt_sel.sv
module brt_sel
    import brt_pkg::*;
#(
    parameter int IP_W  = 16,
    parameter int SEG_W = 8
) (
    input  br_mode_e         mode,
    input  logic [SEG_W-1:0] cur_seg,
    input  logic [SEG_W-1:0] seg_lo,
    input  logic             seg_load,
    input  logic [IP_W-1:0]  abs_addr,
    input  logic [IP_W-1:0]  ind_val,
    input  logic [IP_W-1:0]  rel_ip,
    input  logic [IP_W-1:0]  vec_ip,
    output logic [IP_W-1:0]  raw_ip,
    output logic [SEG_W-1:0] raw_seg,
    output logic             raw_upd
);
    always_comb begin
        unique case (mode)
            BR_ABS: begin
                raw_ip  = abs_addr;
                raw_seg = seg_load ? seg_lo : cur_seg;
                raw_upd = seg_load;
            end
            BR_REL: begin
                raw_ip  = rel_ip;
                raw_seg = cur_seg;
                raw_upd = 1'b0;
            end
            BR_IND: begin
                raw_ip  = ind_val;
                raw_seg = cur_seg;
                raw_upd = 1'b0;
            end
            BR_TRAP: begin
                raw_ip  = vec_ip;
                raw_seg = '0;
                raw_upd = 1'b1;
            end
            default: begin
                raw_ip  = '0;
                raw_seg = cur_seg;
                raw_upd = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/brt_target_gen.sv
module brt_target_gen
    import brt_pkg::*;
#(
    parameter int IP_W   = 16,
    parameter int SEG_W  = 8,
    parameter int OFF_W  = 8,
    parameter int TRAP_W = 7,
    parameter int SOP_W  = 16
) (
    input  logic [1:0]        mode,
    input  logic [SEG_W-1:0]  cur_seg,
    input  logic [IP_W-1:0]   next_ip,
    input  logic [IP_W-1:0]   abs_addr,
    input  logic [OFF_W-1:0]  rel_off,
    input  logic [IP_W-1:0]   ind_val,
    input  logic [TRAP_W-1:0] trap_no,
    input  logic [SOP_W-1:0]  seg_op,
    input  logic              seg_load,
    input  logic              long_insn,
    output logic [SEG_W-1:0]  new_seg,
    output logic [IP_W-1:0]   new_ip,
    output logic              seg_upd,
    output logic              odd_trap,
    output logic              spin
);
    br_mode_e         mode_e;
    logic [IP_W-1:0]  rel_ip;
    logic             self_hit;
    logic [IP_W-1:0]  vec_ip;
    logic [IP_W-1:0]  raw_ip;
    logic [SEG_W-1:0] raw_seg;
    logic             raw_upd;
    logic [SEG_W-1:0] seg_lo;
    logic             unused_seg_hi;
    logic             odd_form;

    assign mode_e = br_mode_e'(mode);
    assign seg_lo = seg_op[SEG_W-1:0];

    generate
        if (SOP_W > SEG_W) begin : g_sop_hi
            assign unused_seg_hi = ^seg_op[SOP_W-1:SEG_W];
        end else begin : g_sop_fit
            assign unused_seg_hi = 1'b0;
        end
    endgenerate

    brt_rel_add #(.IP_W(IP_W), .OFF_W(OFF_W)) u_rel (
        .next_ip   (next_ip),
        .rel_off   (rel_off),
        .long_insn (long_insn),
        .rel_ip    (rel_ip),
        .self_hit  (self_hit)
    );

    brt_trap_vec #(.IP_W(IP_W), .TRAP_W(TRAP_W)) u_vec (
        .trap_no (trap_no),
        .vec_ip  (vec_ip)
    );

    brt_sel #(.IP_W(IP_W), .SEG_W(SEG_W)) u_sel (
        .mode     (mode_e),
        .cur_seg  (cur_seg),
        .seg_lo   (seg_lo),
        .seg_load (seg_load),
        .abs_addr (abs_addr),
        .ind_val  (ind_val),
        .rel_ip   (rel_ip),
        .vec_ip   (vec_ip),
        .raw_ip   (raw_ip),
        .raw_seg  (raw_seg),
        .raw_upd  (raw_upd)
    );

    // Output process: odd target in a form that can carry one overrides the selection
    always_comb begin
        odd_form = (mode_e == BR_ABS) || (mode_e == BR_IND);
        odd_trap = odd_form && raw_ip[0];
        if (odd_trap) begin
            new_ip  = next_ip;
            new_seg = cur_seg;
            seg_upd = 1'b0;
        end else begin
            new_ip  = raw_ip;
            new_seg = raw_seg;
            seg_upd = raw_upd;
        end
        spin = (mode_e == BR_REL) && self_hit;
    end
endmodule

// File: rtl/brt_target_chk.sv
module brt_target_chk #(
    parameter int IP_W   = 16,
    parameter int SEG_W  = 8,
    parameter int OFF_W  = 8,
    parameter int TRAP_W = 7
) (
    input logic [1:0]        mode,
    input logic [SEG_W-1:0]  cur_seg,
    input logic [IP_W-1:0]   next_ip,
    input logic [IP_W-1:0]   ind_val,
    input logic              seg_load,
    input logic [SEG_W-1:0]  new_seg,
    input logic [IP_W-1:0]   new_ip,
    input logic              seg_upd,
    input logic              odd_trap,
    input logic              spin
);
    localparam int VEC_HI = TRAP_W + 2;

    always_comb begin
        // R9: odd request only from forms that can carry an odd target
        p_odd_form_r9: assert (!odd_trap || mode == 2'b00 || mode == 2'b10)
            else $error("odd trap in relative or trap mode");
        // R3: a trapped target leaves the pointer on the following instruction
        p_odd_hold_r3: assert (!odd_trap || (new_ip == next_ip && new_seg == cur_seg && !seg_upd))
            else $error("odd target redirected");
        // R3: a granted absolute or indirect target is even
        p_even_ok_r3: assert (odd_trap || !(mode == 2'b00 || mode == 2'b10) || !new_ip[0])
            else $error("odd target passed without trap");
        // R8: trap vectors live in segment 0 in the table range
        p_trap_vec_r8: assert (mode != 2'b11 ||
                               (new_seg == '0 && seg_upd && new_ip[1:0] == 2'b00 && new_ip[IP_W-1:VEC_HI] == '0))
            else $error("trap vector out of table");
        // R6: spin only in relative mode
        p_spin_mode_r6: assert (!spin || mode == 2'b01)
            else $error("spin outside relative mode");
        // R7: indirect keeps segment and takes the raw register value
        p_ind_raw_r7: assert (mode != 2'b10 || odd_trap ||
                              (new_ip == ind_val && new_seg == cur_seg && !seg_upd))
            else $error("indirect target altered");
        // R1/R2: segment write flag in absolute form follows the load request
        p_abs_upd_r2: assert (mode != 2'b00 || odd_trap || seg_upd == seg_load)
            else $error("absolute segment flag wrong");
    end
endmodule

bind brt_target_gen brt_target_chk #(
    .IP_W(IP_W), .SEG_W(SEG_W), .OFF_W(OFF_W), .TRAP_W(TRAP_W)
) u_chk (
    .mode     (mode),
    .cur_seg  (cur_seg),
    .next_ip  (next_ip),
    .ind_val  (ind_val),
    .seg_load (seg_load),
    .new_seg  (new_seg),
    .new_ip   (new_ip),
    .seg_upd  (seg_upd),
    .odd_trap (odd_trap),
    .spin     (spin)
);

// File: tb/sim_brt_target_gen.sv
module sim_brt_target_gen;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  mode;
    logic [7:0]  cur_seg;
    logic [15:0] next_ip;
    logic [15:0] abs_addr;
    logic [7:0]  rel_off;
    logic [15:0] ind_val;
    logic [6:0]  trap_no;
    logic [15:0] seg_op;
    logic        seg_load;
    logic        long_insn;
    logic [7:0]  new_seg;
    logic [15:0] new_ip;
    logic        seg_upd;
    logic        odd_trap;
    logic        spin;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    brt_target_gen u0 (
        .mode(mode), .cur_seg(cur_seg), .next_ip(next_ip), .abs_addr(abs_addr),
        .rel_off(rel_off), .ind_val(ind_val), .trap_no(trap_no), .seg_op(seg_op),
        .seg_load(seg_load), .long_insn(long_insn), .new_seg(new_seg),
        .new_ip(new_ip), .seg_upd(seg_upd), .odd_trap(odd_trap), .spin(spin)
    );

    // Expected outputs from the requirements; packed {seg, ip, upd, odd, spin}
    function automatic logic [26:0] model();
        logic [15:0] ip;
        logic [7:0]  sg;
        logic        up, od, sp;
        logic [15:0] own;
        int          d;
        sg = cur_seg; up = 0; od = 0; sp = 0;
        own = next_ip - (long_insn ? 16'd4 : 16'd2);
        d = $signed(rel_off);
        case (mode)
            2'd0: begin ip = abs_addr; if (seg_load) begin sg = seg_op[7:0]; up = 1; end end
            2'd1: begin ip = 16'(int'(next_ip) + 2 * d); sp = (ip == own); end
            2'd2: ip = ind_val;
            default: begin ip = 16'(int'(trap_no) * 4); sg = 0; up = 1; end
        endcase
        if ((mode == 2'd0 || mode == 2'd2) && ip[0]) begin
            od = 1; ip = next_ip; sg = cur_seg; up = 0;
        end
        return {sg, ip, up, od, sp};
    endfunction

    task automatic check(input string req);
        logic [26:0] exp_v, act_v;
        #1;
        exp_v = model();
        act_v = {new_seg, new_ip, seg_upd, odd_trap, spin};
        checks++;
        if (act_v !== exp_v) begin
            fails++;
            $display("FAIL %s mode=%0d act seg=%h ip=%h upd=%b odd=%b spin=%b exp seg=%h ip=%h upd=%b odd=%b spin=%b",
                     req, mode, act_v[26:19], act_v[18:3], act_v[2], act_v[1], act_v[0],
                     exp_v[26:19], exp_v[18:3], exp_v[2], exp_v[1], exp_v[0]);
        end
    endtask

    task automatic drive(input logic [1:0] m, input logic [7:0] cs, input logic [15:0] nip,
                         input logic [15:0] ab, input logic [7:0] ro, input logic [15:0] iv,
                         input logic [6:0] tn, input logic [15:0] so, input logic sl,
                         input logic li);
        @(negedge clk);
        mode = m; cur_seg = cs; next_ip = nip; abs_addr = ab; rel_off = ro;
        ind_val = iv; trap_no = tn; seg_op = so; seg_load = sl; long_insn = li;
    endtask

    initial begin
        int seed_v;
        seed_v = $urandom(32'd2024);
        mode = 0; cur_seg = 0; next_ip = 0; abs_addr = 0; rel_off = 0;
        ind_val = 0; trap_no = 0; seg_op = 0; seg_load = 0; long_insn = 0;
        repeat (2) @(posedge clk);
        rst = 0;
        @(negedge clk);
        check("R1 reset");

        drive(0, 8'h3C, 16'h1234, 16'hBEEE, 0, 0, 0, 16'h0000, 0, 0); check("R1 abs");
        drive(0, 8'h3C, 16'h1234, 16'h0F00, 0, 0, 0, 16'hA55A, 1, 0); check("R2 seg load");
        drive(0, 8'h3C, 16'h1234, 16'h0F00, 0, 0, 0, 16'h005A, 1, 0); check("R2 upper bits ignored");
        drive(0, 8'h11, 16'h2000, 16'h4001, 0, 0, 0, 16'h0077, 1, 0); check("R3 odd abs");
        drive(2, 8'h11, 16'h2000, 0, 0, 16'hFFFF, 0, 0, 0, 0);        check("R3 odd ind");
        drive(1, 8'h22, 16'h1000, 0, 8'h7F, 0, 0, 0, 0, 0);           check("R4 fwd max");
        drive(1, 8'h22, 16'h1000, 0, 8'h80, 0, 0, 0, 0, 0);           check("R4 back max");
        drive(1, 8'h22, 16'hFFFE, 0, 8'h05, 0, 0, 0, 0, 0);           check("R4 wrap up");
        drive(1, 8'h22, 16'h0002, 0, 8'hF0, 0, 0, 0, 0, 0);           check("R4 wrap down");
        drive(1, 8'h22, 16'h0400, 0, 8'hFF, 0, 0, 0, 0, 0);           check("R5 short self");
        if (new_ip !== 16'h03FE || spin !== 1'b1) begin
            fails++; $display("FAIL R5 act ip=%h spin=%b exp ip=03fe spin=1", new_ip, spin);
        end
        checks++;
        drive(1, 8'h22, 16'h0400, 0, 8'hFE, 0, 0, 0, 0, 1);           check("R5 long self");
        drive(1, 8'h22, 16'h0400, 0, 8'hFE, 0, 0, 0, 0, 0);           check("R6 no spin");
        drive(2, 8'h5A, 16'h0400, 0, 0, 16'hC0DE, 0, 16'h00FF, 1, 0); check("R7 ind raw");
        drive(3, 8'h5A, 16'h0400, 0, 0, 0, 7'h00, 0, 0, 0);           check("R8 trap 0");
        drive(3, 8'h5A, 16'h0401, 0, 0, 0, 7'h7F, 0, 0, 0);           check("R8 trap 7F");
        if (new_ip !== 16'h01FC) begin
            fails++; $display("FAIL R8 act ip=%h exp ip=01fc", new_ip);
        end
        checks++;
        drive(1, 8'h5A, 16'h0401, 0, 8'h01, 0, 0, 0, 0, 0);           check("R9 rel odd base");

        for (int i = 0; i < 3000; i++) begin
            drive(2'($urandom), 8'($urandom), 16'($urandom), 16'($urandom), 8'($urandom),
                  16'($urandom), 7'($urandom), 16'($urandom), 1'($urandom), 1'($urandom));
            check("R1-R9 random");
        end
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule